// File: doc/BRIEF.md
# Serial Memory Reprogramming Sequencer

This block sits on the host side of a serial, word-erasable nonvolatile memory. It drives the memory's three lines: an active-low enable, a clock and a data line. A request arrives on a valid/ready handshake. It carries a 7-bit word address, an 8-bit data byte and a two-bit mode that chooses an erase phase, a write phase, or both. The block then shifts the control frame into the memory, least significant bit first. After the frame it runs one or two programming phases. In each phase the enable line goes low, a single start pulse is sent on the clock line, and the enable line stays low for a programmed number of cycles before it is released.

In erase-then-write mode the frame is shifted only once and carries the data byte. The erase phase and the write phase that follows differ only in the level held on the data line. Each phase has its own enable cycle and its own start pulse. The handshake applies back-pressure for the whole operation. `req_ready` is high only while the block is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the request fields may change freely and `req_valid` may stay high. The block ignores both until it is idle again. Completion is marked by a one-cycle `done` pulse.

Top module: `eeprog_seq`

## Requirements
- R1: In reset and while idle, `mem_en_n` is 1, `mem_clk` is 0, `mem_dat` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle through the `done` cycle and returns to 1 in the cycle after it. `req_valid` has no effect while `req_ready` is 0, so each operation accepts exactly one request.
- R3: `req_mode` bit 0 requests an erase phase and bit 1 requests a write phase. When both bits are set, the erase phase runs first.
- R4: When `req_mode[1]` is 1, the frame is 16 bits long and is sent in this order: data bit 0 to 7, then address bit 0 to 6, then a control bit of 1.
- R5: For mode 01 the frame is 8 bits long: address bit 0 to 6, then a control bit of 1.
- R6: While the frame is shifted, `mem_en_n` stays 1. Each bit gives `mem_clk` low for BIT_LO_CYC cycles and then high for BIT_HI_CYC cycles. `mem_dat` never changes between two consecutive cycles in which `mem_clk` is high.
- R7: In an erase phase, `mem_dat` is already 1 in the cycle before `mem_en_n` falls and stays 1 as long as `mem_en_n` is 0.
- R8: In a write phase, `mem_dat` is already 0 in the cycle before `mem_en_n` falls and stays 0 as long as `mem_en_n` is 0.
- R9: In each phase, `mem_clk` is 0 when `mem_en_n` falls. The enable stays low for CE_SETUP_CYC cycles, then exactly one start pulse of START_HI_CYC cycles is sent, then PROG_CYC more cycles pass before `mem_en_n` rises.
- R10: In mode 11, no serial clock is sent between the two phases, and `mem_en_n` is high for 2*GAP_CYC cycles between them.
- R11: `done` is high for exactly one cycle. It comes GAP_CYC cycles after the final rise of `mem_en_n`, with `mem_en_n` high and `req_ready` low.
- R12: Mode 00 is accepted. It causes no activity on the memory lines, and `done` is high in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle; a request can be accepted |
| req_mode | input | 2 | Bit 0: erase phase; bit 1: write phase |
| req_addr | input | 7 | Word address |
| req_data | input | 8 | Data byte for a write |
| mem_en_n | output | 1 | Memory enable, active low |
| mem_clk | output | 1 | Serial clock and start pulse |
| mem_dat | output | 1 | Serial data and phase level |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and a new request that is already valid. The bench provokes this by raising `req_valid` with the next request's fields right after acceptance and holding it high through `done`, so that the request is pending both while the block is busy and in the completion cycle. It then judges three things. `req_ready` must be low in the `done` cycle. Exactly one acceptance must be counted per operation. The frame captured for the following operation must match the preloaded fields and not a mixture of the two requests.

// File: rtl/eeprog_pkg.sv
`timescale 1ns/1ps
package eeprog_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned FRAME_W = DATA_W + ADDR_W + 1;
  localparam int unsigned ERASE_W = ADDR_W + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_PH_SETUP,
    ST_PH_EN,
    ST_PH_PULSE,
    ST_PH_PROG,
    ST_PH_REL,
    ST_FIN
  } seq_state_e;

  function automatic int unsigned dur_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Frame in shift order, bit 0 leaves first.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [1:0]        mode,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] data);
    if (mode[1]) return {1'b1, addr, data};
    return {{DATA_W{1'b0}}, 1'b1, addr};
  endfunction

endpackage

// File: rtl/eeprog_timer.sv
`timescale 1ns/1ps
module eeprog_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/eeprog_shifter.sv
`timescale 1ns/1ps
module eeprog_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CW-1:0]     len_in,
  input  logic              shift,
  output logic              bit_o,
  output logic              last_o
);

  logic [WORD_W-1:0] word_q;
  logic [CW-1:0]     left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (load) begin
      word_q <= word_in;
      left_q <= len_in;
    end else if (shift) begin
      word_q <= word_q >> 1;
      left_q <= (left_q != '0) ? left_q - CW'(1) : '0;
    end
  end

  assign bit_o  = word_q[0];
  assign last_o = (left_q == CW'(1));

endmodule

// File: rtl/eeprog_seq.sv
`timescale 1ns/1ps
module eeprog_seq #(
  parameter int unsigned BIT_LO_CYC   = 4,
  parameter int unsigned BIT_HI_CYC   = 4,
  parameter int unsigned GAP_CYC      = 2,
  parameter int unsigned CE_SETUP_CYC = 4,
  parameter int unsigned START_HI_CYC = 4,
  parameter int unsigned PROG_CYC     = 5000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_mode,
  input  logic [eeprog_pkg::ADDR_W-1:0] req_addr,
  input  logic [eeprog_pkg::DATA_W-1:0] req_data,
  output logic                        mem_en_n,
  output logic                        mem_clk,
  output logic                        mem_dat,
  output logic                        done
);
  import eeprog_pkg::*;

  localparam int unsigned MAX_DUR = dur_max(dur_max(dur_max(BIT_LO_CYC, BIT_HI_CYC),
                                                    dur_max(GAP_CYC, CE_SETUP_CYC)),
                                            dur_max(START_HI_CYC, PROG_CYC));
  localparam int unsigned TW    = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR);
  localparam int unsigned LEN_W = $clog2(FRAME_W + 1);

  localparam logic [TW-1:0] T_BLO  = TW'(BIT_LO_CYC - 1);
  localparam logic [TW-1:0] T_BHI  = TW'(BIT_HI_CYC - 1);
  localparam logic [TW-1:0] T_GAP  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] T_SET  = TW'(CE_SETUP_CYC - 1);
  localparam logic [TW-1:0] T_PULS = TW'(START_HI_CYC - 1);
  localparam logic [TW-1:0] T_PROG = TW'(PROG_CYC - 1);

  seq_state_e st_q, st_n;
  logic       erase_ph_q, erase_ph_n;
  logic [1:0] mode_q;
  logic       accept;

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  logic             sh_load, sh_shift, sh_bit, sh_last;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign frame     = pack_frame(req_mode, req_addr, req_data);
  assign frame_len = req_mode[1] ? LEN_W'(FRAME_W) : LEN_W'(ERASE_W);

  eeprog_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  eeprog_shifter #(.WORD_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .word_in (frame),
    .len_in  (frame_len),
    .shift   (sh_shift),
    .bit_o   (sh_bit),
    .last_o  (sh_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      erase_ph_q <= 1'b0;
      mode_q     <= 2'b00;
    end else begin
      st_q       <= st_n;
      erase_ph_q <= erase_ph_n;
      if (accept) mode_q <= req_mode;
    end
  end

  always_comb begin
    st_n       = st_q;
    erase_ph_n = erase_ph_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_mode == 2'b00) begin
            st_n = ST_FIN;
          end else begin
            sh_load  = 1'b1;
            st_n     = ST_BIT_LO;
            tmr_load = 1'b1;
            tmr_val  = T_BLO;
          end
        end
      end
      ST_BIT_LO: begin
        if (tmr_zero) begin
          st_n     = ST_BIT_HI;
          tmr_load = 1'b1;
          tmr_val  = T_BHI;
        end
      end
      ST_BIT_HI: begin
        if (tmr_zero) begin
          sh_shift = 1'b1;
          tmr_load = 1'b1;
          if (sh_last) begin
            st_n       = ST_PH_SETUP;
            erase_ph_n = mode_q[0];
            tmr_val    = T_GAP;
          end else begin
            st_n    = ST_BIT_LO;
            tmr_val = T_BLO;
          end
        end
      end
      ST_PH_SETUP: begin
        if (tmr_zero) begin
          st_n     = ST_PH_EN;
          tmr_load = 1'b1;
          tmr_val  = T_SET;
        end
      end
      ST_PH_EN: begin
        if (tmr_zero) begin
          st_n     = ST_PH_PULSE;
          tmr_load = 1'b1;
          tmr_val  = T_PULS;
        end
      end
      ST_PH_PULSE: begin
        if (tmr_zero) begin
          st_n     = ST_PH_PROG;
          tmr_load = 1'b1;
          tmr_val  = T_PROG;
        end
      end
      ST_PH_PROG: begin
        if (tmr_zero) begin
          st_n     = ST_PH_REL;
          tmr_load = 1'b1;
          tmr_val  = T_GAP;
        end
      end
      ST_PH_REL: begin
        if (tmr_zero) begin
          if (erase_ph_q && mode_q[1]) begin
            erase_ph_n = 1'b0;
            st_n       = ST_PH_SETUP;
            tmr_load   = 1'b1;
            tmr_val    = T_GAP;
          end else begin
            st_n = ST_FIN;
          end
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // Line levels decoded from the state register (Moore).
  always_comb begin
    mem_en_n = 1'b1;
    mem_clk  = 1'b0;
    mem_dat  = 1'b0;
    unique case (st_q)
      ST_BIT_LO:   mem_dat = sh_bit;
      ST_BIT_HI: begin
        mem_clk = 1'b1;
        mem_dat = sh_bit;
      end
      ST_PH_SETUP: mem_dat = erase_ph_q;
      ST_PH_EN: begin
        mem_en_n = 1'b0;
        mem_dat  = erase_ph_q;
      end
      ST_PH_PULSE: begin
        mem_en_n = 1'b0;
        mem_clk  = 1'b1;
        mem_dat  = erase_ph_q;
      end
      ST_PH_PROG: begin
        mem_en_n = 1'b0;
        mem_dat  = erase_ph_q;
      end
      default: ;
    endcase
  end

  assign done = (st_q == ST_FIN);

endmodule

// File: rtl/eeprog_seq_chk.sv
`timescale 1ns/1ps
module eeprog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_en_n,
  input logic mem_clk,
  input logic mem_dat,
  input logic done
);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_en_n && !mem_clk && !mem_dat));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(done));

  // R6
  shift_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clk && $past(mem_clk)) |-> $stable(mem_dat));

  // R7
  phase_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_dat));

  // R9
  enable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en_n) |-> (!mem_clk && $stable(mem_dat)));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_en_n && !req_ready));

endmodule

bind eeprog_seq eeprog_seq_chk u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_en_n  (mem_en_n),
  .mem_clk   (mem_clk),
  .mem_dat   (mem_dat),
  .done      (done)
);

// File: tb/eeprog_seq_test.sv
`timescale 1ns/1ps
module eeprog_seq_test;

  localparam int BLO  = 2;
  localparam int BHI  = 3;
  localparam int GAP  = 2;
  localparam int STLO = 3;
  localparam int STHI = 2;
  localparam int PROG = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_mode = 2'b00;
  logic [6:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic       mem_en_n, mem_clk, mem_dat, done;

  always #5 clk = ~clk;

  eeprog_seq #(
    .BIT_LO_CYC(BLO), .BIT_HI_CYC(BHI), .GAP_CYC(GAP),
    .CE_SETUP_CYC(STLO), .START_HI_CYC(STHI), .PROG_CYC(PROG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
    .mem_en_n(mem_en_n), .mem_clk(mem_clk), .mem_dat(mem_dat), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor state, sampled on the falling clock edge.
  logic [15:0] cap_bits;
  int cap_n = 0, ph_n = 0, ph_gap = 0;
  int ph_lvl[2], ph_len[2], ph_pre[2], ph_pw[2], ph_pulses[2];
  int hold_err = 0, shift_err = 0, ready_err = 0, done_err = 0;
  int acc_n = 0, done_n = 0, done_lat = 0, rel_to_done = 0;
  int since_acc = 0, lo_ce = 0, en_hi_run = 0, hi_run = 0, lo_run = 0;
  bit in_flight = 1'b0;
  logic p_en = 1'b1, p_clk = 1'b0, p_dat = 1'b0, p_done = 1'b0;

  task automatic clear_mon();
    cap_bits = '0; cap_n = 0; ph_n = 0; ph_gap = 0;
    for (int i = 0; i < 2; i++) begin
      ph_lvl[i] = -1; ph_len[i] = 0; ph_pre[i] = 0; ph_pw[i] = 0; ph_pulses[i] = 0;
    end
    hold_err = 0; shift_err = 0; ready_err = 0; done_err = 0;
    acc_n = 0; done_n = 0; done_lat = 0; rel_to_done = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit en_fell  = p_en && !mem_en_n;
      automatic bit en_rose  = !p_en && mem_en_n;
      automatic bit clk_rose = !p_clk && mem_clk;
      automatic bit clk_fell = p_clk && !mem_clk;
      if (in_flight) since_acc++;
      if (mem_clk && p_clk && mem_dat != p_dat) shift_err++;
      if (clk_fell && mem_en_n && hi_run != BHI) shift_err++;
      if (!mem_en_n && clk_fell && ph_n < 2) ph_pw[ph_n] = hi_run;
      if (clk_rose) hi_run = 1; else if (mem_clk) hi_run++;
      if (mem_en_n && clk_rose) begin
        if (cap_n < 16) cap_bits[cap_n] = mem_dat;
        if (cap_n > 0 && lo_run != BLO) shift_err++;
        cap_n++;
      end
      if (clk_fell) lo_run = 1; else if (!mem_clk) lo_run++;
      if (en_fell) begin
        if (ph_n < 2) ph_lvl[ph_n] = int'(mem_dat);
        if (mem_dat != p_dat) hold_err++;
        if (ph_n == 1) ph_gap = en_hi_run;
        lo_ce = 1;
      end else if (!mem_en_n) begin
        lo_ce++;
        if (mem_dat != p_dat) hold_err++;
      end
      if (!mem_en_n && clk_rose && ph_n < 2) begin
        ph_pulses[ph_n]++;
        ph_pre[ph_n] = lo_ce - 1;
      end
      if (en_rose) begin
        if (ph_n < 2) ph_len[ph_n] = lo_ce;
        ph_n++;
      end
      if (en_rose) en_hi_run = 1; else if (mem_en_n) en_hi_run++;
      if (done) begin
        done_n++;
        done_lat = since_acc;
        rel_to_done = en_hi_run;
        if (req_ready) ready_err++;
        if (p_done) done_err++;
        in_flight = 1'b0;
      end else if (in_flight && req_ready) begin
        ready_err++;
      end
      if (req_valid && req_ready) begin
        acc_n++;
        in_flight = 1'b1;
        since_acc = 0;
      end
      p_en = mem_en_n; p_clk = mem_clk; p_dat = mem_dat; p_done = done;
    end
  end

  function automatic logic [15:0] exp_frame(input logic [1:0] m, input logic [6:0] a,
                                            input logic [7:0] d);
    return m[1] ? {1'b1, a, d} : {8'h00, 1'b1, a};
  endfunction

  function automatic int exp_len(input logic [1:0] m);
    if (m == 2'b00) return 0;
    return m[1] ? 16 : 8;
  endfunction

  task automatic judge(input logic [1:0] m, input logic [6:0] a, input logic [7:0] d);
    automatic logic [15:0] ef = exp_frame(m, a, d);
    automatic int el = exp_len(m);
    automatic int nph = int'(m[0]) + int'(m[1]);
    automatic int bad = 0;
    automatic string ftag = m[1] ? "R4 frame" : "R5 frame";
    for (int i = 0; i < el; i++) if (cap_bits[i] != ef[i]) bad++;
    chk(cap_n == el, m == 2'b00 ? "R12 no clocks" : ftag, cap_n, el);
    if (el > 0) chk(bad == 0, ftag, int'(cap_bits), int'(ef));
    chk(ph_n == nph, "R3 phase count", ph_n, nph);
    for (int p = 0; p < nph && p < 2; p++) begin
      automatic int lvl = (p == 0 && m[0]) ? 1 : 0;
      chk(ph_lvl[p] == lvl, lvl ? "R7 erase level" : "R8 write level", ph_lvl[p], lvl);
      chk(ph_pre[p] == STLO, "R9 setup", ph_pre[p], STLO);
      chk(ph_pw[p] == STHI, "R9 pulse width", ph_pw[p], STHI);
      chk(ph_pulses[p] == 1, "R9 pulse count", ph_pulses[p], 1);
      chk(ph_len[p] == STLO + STHI + PROG, "R9 enable low", ph_len[p], STLO + STHI + PROG);
    end
    if (nph == 2) chk(ph_gap == 2 * GAP, "R10 phase gap", ph_gap, 2 * GAP);
    chk(shift_err == 0, "R6 shift timing", shift_err, 0);
    chk(hold_err == 0, "R7 R8 level hold", hold_err, 0);
    chk(acc_n == 1, "R2 acceptances", acc_n, 1);
    chk(ready_err == 0, "R2 ready low", ready_err, 0);
    chk(done_n == 1, "R11 done count", done_n, 1);
    chk(done_err == 0, "R11 done width", done_err, 0);
    if (nph > 0) chk(rel_to_done == GAP + 1, "R11 done timing", rel_to_done, GAP + 1);
    else         chk(done_lat == 1, "R12 done latency", done_lat, 1);
    clear_mon();
  endtask

  // Called at posedge+1. With pre set, the next request is raised right
  // after acceptance and held through done.
  task automatic xact(input logic [1:0] m, input logic [6:0] a, input logic [7:0] d,
                      input bit pre, input logic [1:0] nm, input logic [6:0] na,
                      input logic [7:0] nd);
    if (!req_valid) begin
      req_mode = m; req_addr = a; req_data = d; req_valid = 1'b1;
    end
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    if (pre) begin
      req_mode = nm; req_addr = na; req_data = nd;
    end else begin
      req_valid = 1'b0;
    end
    while (!done) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    judge(m, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] cm, nm;
    logic [6:0] ca, na;
    logic [7:0] cd, nd;
    void'($urandom(32'h5eed_2506));
    clear_mon();
    repeat (2) @(posedge clk);
    #1;
    chk(mem_en_n && !mem_clk && !mem_dat, "R1 lines in reset", {mem_en_n, mem_clk, mem_dat}, 4);
    chk(req_ready && !done, "R1 handshake in reset", {req_ready, done}, 2);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(mem_en_n && !mem_clk && !mem_dat, "R1 idle lines", {mem_en_n, mem_clk, mem_dat}, 4);
    chk(req_ready && !done, "R1 idle handshake", {req_ready, done}, 2);

    // Directed corners
    xact(2'b01, 7'h00, 8'h00, 1'b0, 2'b00, 7'h00, 8'h00);
    xact(2'b10, 7'h7f, 8'hff, 1'b0, 2'b00, 7'h00, 8'h00);
    xact(2'b11, 7'h55, 8'ha5, 1'b0, 2'b00, 7'h00, 8'h00);
    xact(2'b00, 7'h2a, 8'h3c, 1'b0, 2'b00, 7'h00, 8'h00);
    // Pending request overlapping done
    xact(2'b11, 7'h7f, 8'h00, 1'b1, 2'b01, 7'h12, 8'h34);
    xact(2'b01, 7'h12, 8'h34, 1'b1, 2'b00, 7'h01, 8'h80);
    xact(2'b00, 7'h01, 8'h80, 1'b1, 2'b10, 7'h40, 8'h01);
    xact(2'b10, 7'h40, 8'h01, 1'b0, 2'b00, 7'h00, 8'h00);

    // Random traffic
    cm = 2'($urandom()); ca = 7'($urandom()); cd = 8'($urandom());
    for (int i = 0; i < 30; i++) begin
      automatic bit pre = ($urandom() % 3) == 0;
      nm = 2'($urandom()); na = 7'($urandom()); nd = 8'($urandom());
      xact(cm, ca, cd, pre, nm, na, nd);
      cm = nm; ca = na; cd = nd;
    end
    if (req_valid) xact(cm, ca, cd, 1'b0, 2'b00, 7'h00, 8'h00);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule